// File: doc/BRIEF.md
# Burn-In Power Stage Sequencer

This block supervises a two-stage energy-recycling load that burns in DC power supplies. The back-end stage is a grid-tied inverter that can either draw power from the grid to charge the DC link (rectifier mode) or push power back into the grid (inverting mode). The front-end stage is a set of converter channels, one per device under test, that draw current from the supplies and feed it onto the DC link. The sequencer decides which of these stages is on, and in what order, from start, stop and clear commands, from per-channel fault flags and from samples of the bus voltage.

A start first checks the channels in use. If they are clean, it brings up the inverter in rectifier mode and waits until the bus voltage has stayed inside a tolerance window for a set number of consecutive sample ticks. Only then does it switch the inverter to inverting mode and enable the channels. During the run a data-acquisition strobe fires at a fixed programmable interval. A run-length counter, a stop command or a channel fault ends the run. The channels are always switched off first. The inverter stays on through a programmable drain hold so that energy already on the link can leave, and only then turns off. Any abnormal condition lands in a fault state that only a clear command leaves. Every command is acknowledged after a fixed delay.

The states are IDLE, PRECHECK, CHARGE, RUN, DRAIN and FAULT. The transitions are:

- start: IDLE to PRECHECK.
- clean check: PRECHECK to CHARGE.
- dirty check: PRECHECK to FAULT.
- bus settled: CHARGE to RUN.
- charge timeout: CHARGE to FAULT.
- stop during charge: CHARGE to DRAIN.
- stop, run expiry or channel fault: RUN to DRAIN.
- hold elapsed: DRAIN to IDLE, or to FAULT after a channel fault.
- clear: FAULT to IDLE.

Top module: `burnin_seq`

## Requirements
- R1: After reset `inv_en`, `inv_rect`, `ch_en`, `daq_strobe` and `cmd_ack` are 0, and `fault_code` reads 0 (no fault).
- R2: A start in IDLE spends one cycle in PRECHECK with every output off. With no fault on a used channel, the next cycle has `inv_en`=1 and `inv_rect`=1 (rectifier mode) with `ch_en`=0, and the inverter is never enabled outside rectifier mode at its first enabled cycle.
- R3: The bus counts as settled once `stable_need` consecutive `bus_tick` samples found `|bus_v - bus_ref| <= bus_win`. A sample outside the window restarts the count. The cycle after the settling sample, RUN begins with `ch_en`=`ch_use` and `inv_rect`=0. Channels are on only while the inverter is on in inverting mode.
- R4: In PRECHECK, any set bit of `ch_fault & ch_use` leads to FAULT with `fault_code`=1 and `fault_chan`= lowest such index, and the inverter is never enabled. Faults on unused channels are ignored.
- R5: If the bus has not settled after `charge_limit` cycles in CHARGE, the block enters FAULT with `inv_en`=0 and `fault_code`=2.
- R6: On leaving RUN, `ch_en` goes to 0 while `inv_en` stays 1 for exactly `drain_hold`+1 cycles, after which `inv_en` is 0. The inverter never turns off in a cycle that had a channel enabled.
- R7: RUN lasts exactly `test_cycles` cycles when no stop or fault arrives, and then the stop order of R6 runs by itself.
- R8: `daq_strobe` is high only in RUN, on the RUN cycles numbered `daq_period`-1, 2*`daq_period`-1, and so on (counting from 0), so a run of D cycles gives D/`daq_period` strobes.
- R9: A fault on a used channel during RUN starts the ordered stop, sets `fault_code`=3 and `fault_chan` to the lowest faulting index. After the drain hold the block rests in FAULT with the inverter off.
- R10: `cmd_clear` in FAULT returns to IDLE and resets `fault_code` to 0. In any other state it has no effect on the outputs.
- R11: Each cycle with any of `cmd_start`, `cmd_stop` or `cmd_clear` high produces a one-cycle `cmd_ack` exactly ACK_DLY cycles later, whether or not the command was acted on. A stop in IDLE changes nothing else.
- R12: When a channel fault and a stop arrive in the same RUN cycle, the fault is recorded (`fault_code`=3).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cmd_start | input | 1 | Start command pulse |
| cmd_stop | input | 1 | Stop command pulse |
| cmd_clear | input | 1 | Fault clear command pulse |
| ch_use | input | NCH | Channels taking part in the test |
| ch_fault | input | NCH | Per-channel abnormal flags |
| bus_v | input | VW | Measured DC-link voltage |
| bus_ref | input | VW | Required DC-link voltage |
| bus_win | input | VW | Allowed deviation from bus_ref |
| bus_tick | input | 1 | Bus sample strobe |
| stable_need | input | CW | Consecutive in-window samples needed |
| charge_limit | input | TW | Charge timeout in cycles |
| drain_hold | input | TW | Extra inverter-on cycles after channels stop |
| daq_period | input | TW | Acquisition strobe interval in cycles |
| test_cycles | input | TW | Run length in cycles |
| inv_en | output | 1 | Inverter enable |
| inv_rect | output | 1 | 1 = rectifier mode, 0 = inverting mode |
| ch_en | output | NCH | Front-end channel enables |
| daq_strobe | output | 1 | Data-acquisition strobe |
| cmd_ack | output | 1 | Command acknowledge pulse |
| fault_code | output | 2 | 0 none, 1 check fault, 2 charge timeout, 3 run fault |
| fault_chan | output | IW | Index of the faulting channel |

## Verification
A wrong state register shows on the enables in the same cycle it goes wrong. The outputs are decoded straight from the state, so channels switched on without a settled bus, an inverter in the wrong mode, or an inverter dropped while channels still run are all visible at once. A wrong phase counter shows one cycle late as a RUN or drain window that is a cycle too long or too short. A wrong acquisition counter shows as a strobe count that differs from run length divided by period. A wrong fault register shows in `fault_code` and `fault_chan` on the cycle after the fault is seen, and it persists until clear.

// File: rtl/burnin_seq_pkg.sv
package burnin_seq_pkg;

    typedef enum logic [2:0] {
        SEQ_IDLE     = 3'd0,
        SEQ_PRECHECK = 3'd1,
        SEQ_CHARGE   = 3'd2,
        SEQ_RUN      = 3'd3,
        SEQ_DRAIN    = 3'd4,
        SEQ_FAULT    = 3'd5
    } seq_state_e;

    typedef enum logic [1:0] {
        FLT_NONE      = 2'd0,
        FLT_PRECHECK  = 2'd1,
        FLT_CHARGE_TO = 2'd2,
        FLT_RUN_CH    = 2'd3
    } fault_code_e;

endpackage

// File: rtl/burnin_seq_bus_mon.sv
module burnin_seq_bus_mon #(
    parameter int VW = 12,
    parameter int CW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          en,
    input  logic          tick,
    input  logic [VW-1:0] v_meas,
    input  logic [VW-1:0] v_target,
    input  logic [VW-1:0] v_tol,
    input  logic [CW-1:0] need,
    output logic          stable
);
    logic [VW:0]   dev;
    logic          in_win;
    logic [CW-1:0] run_len;

    // absolute deviation, one bit wider so the subtraction never wraps
    always_comb begin
        if (v_meas >= v_target) begin
            dev = {1'b0, v_meas} - {1'b0, v_target};
        end else begin
            dev = {1'b0, v_target} - {1'b0, v_meas};
        end
        in_win = (dev <= {1'b0, v_tol});
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            run_len <= '0;
        end else if (!en) begin
            run_len <= '0;
        end else if (tick) begin
            if (!in_win) begin
                run_len <= '0;
            end else if (run_len != '1) begin
                run_len <= run_len + 1'b1;
            end
        end
    end

    assign stable = en && (run_len >= need);

endmodule

// File: rtl/burnin_seq_prio.sv
module burnin_seq_prio #(
    parameter int NCH = 4,
    parameter int IW  = 2
) (
    input  logic [NCH-1:0] req,
    output logic           hit,
    output logic [IW-1:0]  idx
);
    always_comb begin
        hit = |req;
        idx = '0;
        for (int i = NCH - 1; i >= 0; i--) begin
            if (req[i]) begin
                idx = IW'(i);
            end
        end
    end
endmodule

// File: rtl/burnin_seq_ack.sv
module burnin_seq_ack #(
    parameter int DLY = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic seen,
    output logic ack
);
    logic [DLY-1:0] pipe;

    generate
        if (DLY == 1) begin : g_single
            always_ff @(posedge clk) begin
                if (!rst_n) pipe <= '0;
                else        pipe <= seen;
            end
        end else begin : g_shift
            always_ff @(posedge clk) begin
                if (!rst_n) pipe <= '0;
                else        pipe <= {pipe[DLY-2:0], seen};
            end
        end
    endgenerate

    assign ack = pipe[DLY-1];
endmodule

// File: rtl/burnin_seq.sv
module burnin_seq
    import burnin_seq_pkg::*;
#(
    parameter int NCH     = 4,
    parameter int VW      = 12,
    parameter int CW      = 8,
    parameter int TW      = 16,
    parameter int ACK_DLY = 4,
    localparam int IW     = (NCH > 1) ? $clog2(NCH) : 1
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           cmd_start,
    input  logic           cmd_stop,
    input  logic           cmd_clear,
    input  logic [NCH-1:0] ch_use,
    input  logic [NCH-1:0] ch_fault,
    input  logic [VW-1:0]  bus_v,
    input  logic [VW-1:0]  bus_ref,
    input  logic [VW-1:0]  bus_win,
    input  logic           bus_tick,
    input  logic [CW-1:0]  stable_need,
    input  logic [TW-1:0]  charge_limit,
    input  logic [TW-1:0]  drain_hold,
    input  logic [TW-1:0]  daq_period,
    input  logic [TW-1:0]  test_cycles,
    output logic           inv_en,
    output logic           inv_rect,
    output logic [NCH-1:0] ch_en,
    output logic           daq_strobe,
    output logic           cmd_ack,
    output logic [1:0]     fault_code,
    output logic [IW-1:0]  fault_chan
);
    localparam logic [TW:0] ONE_W = (TW + 1)'(1);

    seq_state_e    state_q, state_d;
    fault_code_e   code_q;
    logic [IW-1:0] chan_q;
    logic [TW-1:0] phase_cnt;
    logic [TW-1:0] daq_cnt;
    logic          bus_ok;
    logic          flt_hit;
    logic [IW-1:0] flt_idx;
    logic          charge_over;
    logic          run_over;
    logic          drain_over;
    logic          daq_hit;
    logic          any_cmd;

    // ---------------- helpers ----------------
    burnin_seq_bus_mon #(.VW(VW), .CW(CW)) u_bus_mon (
        .clk      (clk),
        .rst_n    (rst_n),
        .en       (state_q == SEQ_CHARGE),
        .tick     (bus_tick),
        .v_meas   (bus_v),
        .v_target (bus_ref),
        .v_tol    (bus_win),
        .need     (stable_need),
        .stable   (bus_ok)
    );

    burnin_seq_prio #(.NCH(NCH), .IW(IW)) u_prio (
        .req (ch_fault & ch_use),
        .hit (flt_hit),
        .idx (flt_idx)
    );

    assign any_cmd = cmd_start | cmd_stop | cmd_clear;

    burnin_seq_ack #(.DLY(ACK_DLY)) u_ack (
        .clk   (clk),
        .rst_n (rst_n),
        .seen  (any_cmd),
        .ack   (cmd_ack)
    );

    // ---------------- window ends ----------------
    // a limit of zero behaves like one so every window lasts at least a cycle
    assign charge_over = ({1'b0, phase_cnt} + ONE_W) >= {1'b0, charge_limit};
    assign run_over    = ({1'b0, phase_cnt} + ONE_W) >= {1'b0, test_cycles};
    assign drain_over  = phase_cnt >= drain_hold;
    assign daq_hit     = (state_q == SEQ_RUN) &&
                         (({1'b0, daq_cnt} + ONE_W) >= {1'b0, daq_period});

    // ---------------- next state ----------------
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            SEQ_IDLE: begin
                if (cmd_start) state_d = SEQ_PRECHECK;
            end
            SEQ_PRECHECK: begin
                if (flt_hit) state_d = SEQ_FAULT;
                else         state_d = SEQ_CHARGE;
            end
            SEQ_CHARGE: begin
                if (cmd_stop)         state_d = SEQ_DRAIN;
                else if (bus_ok)      state_d = SEQ_RUN;
                else if (charge_over) state_d = SEQ_FAULT;
            end
            SEQ_RUN: begin
                if (flt_hit || cmd_stop || run_over) state_d = SEQ_DRAIN;
            end
            SEQ_DRAIN: begin
                if (drain_over) begin
                    state_d = (code_q == FLT_RUN_CH) ? SEQ_FAULT : SEQ_IDLE;
                end
            end
            SEQ_FAULT: begin
                if (cmd_clear) state_d = SEQ_IDLE;
            end
            default: state_d = SEQ_IDLE;
        endcase
    end

    // ---------------- state register ----------------
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= SEQ_IDLE;
        else        state_q <= state_d;
    end

    // ---------------- phase and acquisition counters ----------------
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            phase_cnt <= '0;
        end else if (state_d != state_q) begin
            phase_cnt <= '0;
        end else if (phase_cnt != '1) begin
            phase_cnt <= phase_cnt + 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            daq_cnt <= '0;
        end else if (state_q != SEQ_RUN || daq_hit) begin
            daq_cnt <= '0;
        end else begin
            daq_cnt <= daq_cnt + 1'b1;
        end
    end

    // ---------------- fault record ----------------
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            code_q <= FLT_NONE;
            chan_q <= '0;
        end else begin
            unique case (state_q)
                SEQ_IDLE: begin
                    if (cmd_start) begin
                        code_q <= FLT_NONE;
                        chan_q <= '0;
                    end
                end
                SEQ_PRECHECK: begin
                    if (flt_hit) begin
                        code_q <= FLT_PRECHECK;
                        chan_q <= flt_idx;
                    end
                end
                SEQ_CHARGE: begin
                    if (state_d == SEQ_FAULT) code_q <= FLT_CHARGE_TO;
                end
                SEQ_RUN: begin
                    if (flt_hit) begin
                        code_q <= FLT_RUN_CH;
                        chan_q <= flt_idx;
                    end
                end
                SEQ_FAULT: begin
                    if (cmd_clear) begin
                        code_q <= FLT_NONE;
                        chan_q <= '0;
                    end
                end
                default: begin
                end
            endcase
        end
    end

    // ---------------- outputs ----------------
    always_comb begin
        inv_en   = 1'b0;
        inv_rect = 1'b0;
        ch_en    = '0;
        unique case (state_q)
            SEQ_CHARGE: begin
                inv_en   = 1'b1;
                inv_rect = 1'b1;
            end
            SEQ_RUN: begin
                inv_en = 1'b1;
                ch_en  = ch_use;
            end
            SEQ_DRAIN: begin
                inv_en = 1'b1;
            end
            default: begin
            end
        endcase
    end

    assign daq_strobe = daq_hit;
    assign fault_code = code_q;
    assign fault_chan = chan_q;

endmodule

// File: rtl/burnin_seq_chk.sv
module burnin_seq_chk #(
    parameter int NCH = 4
) (
    input logic           clk,
    input logic           rst_n,
    input logic           inv_en,
    input logic           inv_rect,
    input logic [NCH-1:0] ch_en,
    input logic           daq_strobe,
    input logic [1:0]     fault_code
);
    // channels only while the inverter pushes energy out
    assert_ch_needs_inverter_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (|ch_en) |-> (inv_en && !inv_rect));

    // the inverter always wakes up in rectifier mode
    assert_start_in_rect_R2: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(inv_en) |-> inv_rect);

    // inverter never drops while a channel was still enabled
    assert_drop_after_channels_R6: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(inv_en) |-> ($past(ch_en) == '0));

    // a charge timeout leaves the inverter off
    assert_timeout_off_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (fault_code == 2'd2) |-> !inv_en);

    // acquisition strobe only during the run
    assert_strobe_in_run_R8: assert property (@(posedge clk) disable iff (!rst_n)
        daq_strobe |-> (inv_en && !inv_rect));

    // rectifier mode only with the inverter on
    assert_rect_implies_on_R2: assert property (@(posedge clk) disable iff (!rst_n)
        inv_rect |-> inv_en);
endmodule

bind burnin_seq burnin_seq_chk #(.NCH(NCH)) u_burnin_seq_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .inv_en     (inv_en),
    .inv_rect   (inv_rect),
    .ch_en      (ch_en),
    .daq_strobe (daq_strobe),
    .fault_code (fault_code)
);

// File: tb/test_burnin_seq.sv
`timescale 1ns/1ps
module test_burnin_seq;
    localparam int NCH = 4, VW = 12, CW = 8, TW = 16, ACK_DLY = 4;
    localparam int IW = 2;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic cmd_start = 0, cmd_stop = 0, cmd_clear = 0;
    logic [NCH-1:0] ch_use = '0, ch_fault = '0;
    logic [VW-1:0] bus_v = '0, bus_ref = 12'd750, bus_win = 12'd10;
    logic bus_tick = 0;
    logic [CW-1:0] stable_need = 8'd2;
    logic [TW-1:0] charge_limit = 16'd1000, drain_hold = 16'd3;
    logic [TW-1:0] daq_period = 16'd4, test_cycles = 16'd20;
    logic inv_en, inv_rect, daq_strobe, cmd_ack;
    logic [NCH-1:0] ch_en;
    logic [1:0] fault_code;
    logic [IW-1:0] fault_chan;

    int n_chk = 0, n_fail = 0;
    bit done = 0;

    always #4 clk = ~clk;   // 125 MHz

    burnin_seq #(.NCH(NCH), .VW(VW), .CW(CW), .TW(TW), .ACK_DLY(ACK_DLY)) i_burnin_seq (
        .clk(clk), .rst_n(rst_n), .cmd_start(cmd_start), .cmd_stop(cmd_stop),
        .cmd_clear(cmd_clear), .ch_use(ch_use), .ch_fault(ch_fault),
        .bus_v(bus_v), .bus_ref(bus_ref), .bus_win(bus_win), .bus_tick(bus_tick),
        .stable_need(stable_need), .charge_limit(charge_limit), .drain_hold(drain_hold),
        .daq_period(daq_period), .test_cycles(test_cycles), .inv_en(inv_en),
        .inv_rect(inv_rect), .ch_en(ch_en), .daq_strobe(daq_strobe), .cmd_ack(cmd_ack),
        .fault_code(fault_code), .fault_chan(fault_chan));

    task automatic step();
        @(posedge clk);
        #1;
    endtask

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    function automatic int exp_strobes(input int dur, input int per);
        return dur / per;
    endfunction

    function automatic int lowest(input logic [NCH-1:0] m);
        for (int i = 0; i < NCH; i++) if (m[i]) return i;
        return 0;
    endfunction

    task automatic start_to_charge();
        cmd_start = 1; step(); cmd_start = 0;
        step();
    endtask

    task automatic stop_and_drain();
        cmd_stop = 1; step(); cmd_stop = 0;
        for (int g = 0; g < 100 && inv_en; g++) step();
    endtask

    task automatic session(input int need, input int drain, input int per, input int dur,
                           input logic [NCH-1:0] use_m);
        int run_cyc, strobes, drain_cyc;
        stable_need = CW'(need); drain_hold = TW'(drain);
        daq_period = TW'(per); test_cycles = TW'(dur);
        ch_use = use_m; bus_v = bus_ref; ch_fault = '0;
        start_to_charge();
        chk(inv_en && inv_rect && ch_en == 0, "R2 charge entry", {inv_en, inv_rect}, 3);
        for (int k = 0; k < need; k++) begin
            bus_tick = 1; step(); bus_tick = 0;
        end
        step();
        chk(ch_en == use_m && !inv_rect, "R3 run entry", ch_en, use_m);
        run_cyc = 0; strobes = 0;
        for (int g = 0; g < 5000 && ch_en != 0; g++) begin
            run_cyc++;
            if (daq_strobe) strobes++;
            step();
        end
        chk(run_cyc == dur, "R7 run length", run_cyc, dur);
        chk(strobes == exp_strobes(dur, per), "R8 strobe count", strobes, exp_strobes(dur, per));
        drain_cyc = 0;
        for (int g = 0; g < 5000 && inv_en; g++) begin
            drain_cyc++;
            chk(ch_en == 0 && !daq_strobe, "R6 channels off in drain", ch_en, 0);
            step();
        end
        chk(drain_cyc == drain + 1, "R6 drain hold", drain_cyc, drain + 1);
        chk(fault_code == 0, "R7 clean stop", fault_code, 0);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        int k;
        void'($urandom(32'd20240611));
        repeat (4) step();
        rst_n = 1;
        step();
        // R1 reset state
        chk(!inv_en && !inv_rect && ch_en == 0 && !daq_strobe && !cmd_ack,
            "R1 outputs after reset", {inv_en, inv_rect, daq_strobe, cmd_ack}, 0);
        chk(fault_code == 0, "R1 fault code", fault_code, 0);

        // R11 ack delay, stop in IDLE ignored
        cmd_stop = 1; step(); cmd_stop = 0;
        k = 0;
        while (!cmd_ack && k < 20) begin
            chk(!inv_en, "R11 stop ignored in idle", inv_en, 0);
            step(); k++;
        end
        chk(k == ACK_DLY - 1, "R11 ack delay", k, ACK_DLY - 1);
        step();
        chk(!cmd_ack, "R11 ack single cycle", cmd_ack, 0);

        // R3 window restart
        stable_need = 8'd3; ch_use = 4'b0011; bus_v = bus_ref + 12'd10;
        start_to_charge();
        bus_tick = 1; step(); step();
        bus_v = bus_ref - 12'd11; step();
        bus_v = bus_ref - 12'd10; step(); step();
        bus_tick = 0; step();
        chk(ch_en == 0 && inv_rect, "R3 outside sample restarts count", ch_en, 0);
        bus_tick = 1; step(); bus_tick = 0; step();
        chk(ch_en == 4'b0011, "R3 settle after restart", ch_en, 3);
        // R10 clear ignored in RUN
        cmd_clear = 1; step(); cmd_clear = 0;
        chk(ch_en == 4'b0011 && inv_en, "R10 clear ignored in run", ch_en, 3);
        stop_and_drain();
        chk(!inv_en && fault_code == 0, "R6 stop reaches idle", inv_en, 0);

        // R4 precheck fault, lowest used index
        ch_use = 4'b0110; ch_fault = 4'b1100;
        cmd_start = 1; step(); cmd_start = 0;
        chk(!inv_en && ch_en == 0, "R2 precheck outputs off", inv_en, 0);
        step();
        chk(!inv_en && fault_code == 1, "R4 precheck fault code", fault_code, 1);
        chk(fault_chan == lowest(ch_use & ch_fault), "R4 fault channel", fault_chan,
            lowest(ch_use & ch_fault));
        step();
        chk(!inv_en, "R4 inverter stays off", inv_en, 0);
        cmd_clear = 1; step(); cmd_clear = 0;
        chk(fault_code == 0, "R10 clear from fault", fault_code, 0);
        // unused channel faults ignored
        ch_fault = 4'b1001;
        start_to_charge();
        chk(inv_en && inv_rect && fault_code == 0, "R4 unused fault ignored", fault_code, 0);

        // R5 charge timeout (currently in CHARGE since entry)
        stop_and_drain();
        ch_fault = '0; charge_limit = 16'd6; bus_v = bus_ref + 12'd200;
        start_to_charge();
        repeat (5) step();
        chk(inv_en && inv_rect, "R5 still charging before limit", inv_en, 1);
        step();
        chk(!inv_en && fault_code == 2, "R5 timeout fault", fault_code, 2);
        cmd_clear = 1; step(); cmd_clear = 0;
        charge_limit = 16'd1000;

        // R9 / R12 run fault together with stop
        ch_use = 4'b1111; bus_v = bus_ref; stable_need = 8'd1; drain_hold = 16'd2;
        test_cycles = 16'd500;
        start_to_charge();
        bus_tick = 1; step(); bus_tick = 0; step();
        chk(ch_en == 4'b1111, "R3 run with all channels", ch_en, 15);
        ch_fault = 4'b1010; cmd_stop = 1; step(); ch_fault = '0; cmd_stop = 0;
        chk(ch_en == 0 && inv_en, "R9 channels off first", {ch_en, inv_en}, 1);
        chk(fault_code == 3, "R12 fault beats stop", fault_code, 3);
        chk(fault_chan == 1, "R9 faulting channel", fault_chan, 1);
        step(); step();
        chk(inv_en, "R9 drain hold in progress", inv_en, 1);
        step();
        chk(!inv_en && fault_code == 3, "R9 rests in fault", fault_code, 3);
        cmd_start = 1; step(); cmd_start = 0; step();
        chk(!inv_en, "R10 start ignored in fault", inv_en, 0);
        cmd_clear = 1; step(); cmd_clear = 0;
        chk(fault_code == 0 && !inv_en, "R10 clear after run fault", fault_code, 0);

        // randomised sessions
        for (int s = 0; s < 8; s++) begin
            session(1 + int'($urandom % 4), int'($urandom % 8), 1 + int'($urandom % 6),
                    5 + int'($urandom % 36), NCH'(1 + ($urandom % 15)));
            repeat (3) step();
        end

        done = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule